// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one column command into the sequence of column addresses a DRAM burst walks through inside an open page. A mode word, captured only when the mode register is loaded, sets the burst length (one, two, four or eight beats, or a whole page) and the ordering inside an aligned group (linear wrap or XOR pattern). A start strobe with a starting column launches a burst. From the next cycle on, the block presents one column per clock with a valid flag, and it raises a last-beat flag on the closing column of a fixed-length burst.

A burst ends when its length runs out, when a stop request arrives, or when a new column command replaces it. A new command may arrive on any cycle, including the cycle right after the previous one. Page mode counts across the full column range, wraps from the top column back to zero, and runs until it is stopped or replaced. The column width is a parameter: 10 bits for the byte-wide organisation, 11 when the nibble-wide part adds a column bit.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid and col_last are low and col_out is zero. The mode is one beat with linear ordering, so a start without any mode load yields a single beat flagged last.
- R2: mode_len and mode_ilv are captured only on a clock edge where mode_load is high. Length codes are 0 = 1 beat, 1 = 2, 2 = 4, 3 = 8 and 7 = whole page. Codes 4 to 6 act as one beat. mode_ilv = 1 selects XOR ordering. A change on mode_len or mode_ilv while mode_load is low has no effect on later bursts.
- R3: On the clock edge where start is high, start_col is taken. In the following cycle col_valid is high and col_out equals start_col.
- R4: With linear ordering and burst length BL of 2, 4 or 8, beat i keeps the column bits above log2(BL) equal to those of start_col. Its low log2(BL) bits equal (start low bits + i) mod BL.
- R5: With XOR ordering and BL of 2, 4 or 8, beat i keeps the upper bits of start_col and its low log2(BL) bits equal start low bits XOR i.
- R6: A fixed-length burst shows exactly BL valid cycles. col_last is high only on the final one, and col_valid is low in the cycle after it unless a new start arrived.
- R7: In page mode each beat is the previous column plus one modulo 2^COL_W, so the top column is followed by zero. mode_ilv has no effect in page mode, col_last never rises, and the burst runs until stop or start.
- R8: When stop is high on a clock edge with no start, the column shown in that cycle is the last one and col_valid is low in the next cycle. This holds at every burst length. A stop while idle has no effect.
- R9: A start during an active burst restarts the sequence at the new column in the next cycle, with the beat count reset. Start takes priority over stop on the same edge.
- R10: Whenever col_valid is low, col_out is zero and col_last is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Capture mode_len and mode_ilv on this edge |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = XOR ordering, 0 = linear ordering |
| start | input | 1 | Column command strobe |
| start_col | input | COL_W | Starting column of the burst |
| stop | input | 1 | End the current burst after the shown beat |
| col_out | output | COL_W | Current column, zero when idle |
| col_valid | output | 1 | col_out holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The first column of a burst is due one cycle after the edge that samples start. Each later beat follows one cycle after the one before it. The drop of col_valid after a stop or a final beat lands in the cycle after that edge, and a mode load affects bursts from the next edge on. The bench drives inputs just after a rising edge and samples outputs one time unit later. Each comparison therefore sees the state produced by exactly one register update. Expected columns come from an arithmetic model built on division and remainder by the burst length, not from masks.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam logic [2:0] LEN_1    = 3'd0;
  localparam logic [2:0] LEN_2    = 3'd1;
  localparam logic [2:0] LEN_4    = 3'd2;
  localparam logic [2:0] LEN_8    = 3'd3;
  localparam logic [2:0] LEN_PAGE = 3'd7;

  typedef struct packed {
    logic [2:0] len;
    logic       ilv;
  } mode_t;

  function automatic logic len_is_page(input logic [2:0] len);
    return len == LEN_PAGE;
  endfunction
endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import bcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] len_in,
  input  logic       ilv_in,
  output mode_t      mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{len: LEN_1, ilv: 1'b0};
    end else if (load) begin
      mode_q <= '{len: len_in, ilv: ilv_in};
    end
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  logic             last_beat,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic             halt
);
  // a burst closes on stop or on its final beat, unless a new command replaces it
  assign halt = active & ~start & (stop | last_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      beat   <= '0;
    end else if (start) begin
      active <= 1'b1;
      base   <= start_col;
      beat   <= '0;
    end else if (halt) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (active) begin
      beat   <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  mode_t            mode,
  input  logic             active,
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col,
  output logic             last_beat,
  output logic             page
);
  // bits of the column that move during a burst
  function automatic logic [COL_W-1:0] beat_mask(input logic [2:0] len);
    case (len)
      LEN_2:    return COL_W'(1);
      LEN_4:    return COL_W'(3);
      LEN_8:    return COL_W'(7);
      LEN_PAGE: return '1;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] map_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] i,
                                               input logic [COL_W-1:0] m,
                                               input logic             x);
    logic [COL_W-1:0] moved;
    moved = x ? (b ^ i) : (b + i);
    return (b & ~m) | (moved & m);
  endfunction

  logic [COL_W-1:0] mask;
  logic             ilv_eff;

  assign page      = len_is_page(mode.len);
  assign mask      = beat_mask(mode.len);
  assign ilv_eff   = mode.ilv & ~page;
  assign col       = active ? map_col(base, beat, mask, ilv_eff) : '0;
  assign last_beat = active & ~page & (beat == mask);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [2:0]       mode_len,
  input  logic             mode_ilv,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last
);
  mode_t            mode_q;
  logic             active;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic             last_beat;
  logic             burst_halt;
  logic             full_mode;

  bcg_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (mode_load),
    .len_in (mode_len),
    .ilv_in (mode_ilv),
    .mode_q (mode_q)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .stop      (stop),
    .last_beat (last_beat),
    .active    (active),
    .base      (base),
    .beat      (beat),
    .halt      (burst_halt)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .mode      (mode_q),
    .active    (active),
    .base      (base),
    .beat      (beat),
    .col       (col_out),
    .last_beat (last_beat),
    .page      (full_mode)
  );

  assign col_valid = active;
  assign col_last  = last_beat;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic             full_mode,
  input logic             burst_halt
);
  p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_out == $past(start_col)));

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && stop && !start) |=> !col_valid);

  p_halt_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_halt |=> !col_valid);

  p_page_nolast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode |-> !col_last);

  p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full_mode && !stop && !start && !mode_load)
      |=> (col_valid && col_out == COL_W'($past(col_out) + 1'b1)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (col_out == '0 && !col_last));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_load  (mode_load),
  .start      (start),
  .start_col  (start_col),
  .stop       (stop),
  .col_out    (col_out),
  .col_valid  (col_valid),
  .col_last   (col_last),
  .full_mode  (full_mode),
  .burst_halt (burst_halt)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 10;

  typedef struct packed {
    logic [2:0] len;
    logic       ilv;
    logic [9:0] col;
    logic [3:0] n_page;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{len: 3'd0, ilv: 1'b0, col: 10'h155, n_page: 4'd0},
    '{len: 3'd1, ilv: 1'b0, col: 10'h3FF, n_page: 4'd0},
    '{len: 3'd2, ilv: 1'b0, col: 10'h006, n_page: 4'd0},
    '{len: 3'd3, ilv: 1'b0, col: 10'h0FD, n_page: 4'd0},
    '{len: 3'd1, ilv: 1'b1, col: 10'h011, n_page: 4'd0},
    '{len: 3'd2, ilv: 1'b1, col: 10'h2A5, n_page: 4'd0},
    '{len: 3'd3, ilv: 1'b1, col: 10'h00B, n_page: 4'd0},
    '{len: 3'd3, ilv: 1'b1, col: 10'h000, n_page: 4'd0},
    '{len: 3'd7, ilv: 1'b0, col: 10'h3FC, n_page: 4'd7},
    '{len: 3'd7, ilv: 1'b1, col: 10'h123, n_page: 4'd5},
    '{len: 3'd5, ilv: 1'b0, col: 10'h0AA, n_page: 4'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_load = 1'b0;
  logic [2:0]       mode_len = 3'd0;
  logic             mode_ilv = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_load (mode_load),
    .mode_len  (mode_len),
    .mode_ilv  (mode_ilv),
    .start     (start),
    .start_col (start_col),
    .stop      (stop),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_mode(input logic [2:0] len, input logic ilv);
    mode_load = 1'b1;
    mode_len  = len;
    mode_ilv  = ilv;
    tick();
    mode_load = 1'b0;
  endtask

  task automatic launch(input logic [COL_W-1:0] c);
    start     = 1'b1;
    start_col = c;
    tick();
    start     = 1'b0;
  endtask

  // burst length in beats; 0 stands for page mode
  function automatic int beats_of(input logic [2:0] len);
    if (len == 3'd7) return 0;
    if (len <= 3'd3) return 1 << len;
    return 1;
  endfunction

  function automatic int exp_col(input logic [2:0] len, input logic ilv,
                                 input int s, input int i);
    int bl;
    int lo;
    bl = beats_of(len);
    if (bl == 0) return (s + i) % 1024;
    lo = s % bl;
    lo = ilv ? (lo ^ i) : ((lo + i) % bl);
    return (s / bl) * bl + lo;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, all requirements unverified");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3;
    chk("R1 valid in reset", int'(col_valid), 0);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 valid after reset", int'(col_valid), 0);
    chk("R1 col after reset", int'(col_out), 0);
    chk("R1 last after reset", int'(col_last), 0);

    // R1: default mode is a single linear beat
    launch(10'h0F0);
    chk("R1 default col", int'(col_out), 'h0F0);
    chk("R1 default last", int'(col_last), 1);
    tick();
    chk("R1 default ends", int'(col_valid), 0);

    // table walk: R4 linear, R5 XOR, R6 length, R7 page, R2 reserved codes
    for (int v = 0; v < NVEC; v++) begin
      int nb;
      logic page;
      page = (beats_of(VECS[v].len) == 0);
      nb   = page ? int'(VECS[v].n_page) : beats_of(VECS[v].len);
      load_mode(VECS[v].len, VECS[v].ilv);
      launch(VECS[v].col);
      for (int i = 0; i < nb; i++) begin
        chk(page ? "R7 page col" : (VECS[v].ilv ? "R5 xor col" : "R4 linear col"),
            int'(col_out), exp_col(VECS[v].len, VECS[v].ilv, int'(VECS[v].col), i));
        chk("R6 valid in burst", int'(col_valid), 1);
        chk(page ? "R7 no last in page" : "R6 last flag", int'(col_last),
            (!page && i == nb - 1) ? 1 : 0);
        if (page && i == nb - 1) stop = 1'b1;
        tick();
        stop = 1'b0;
      end
      chk(page ? "R8 page stopped" : "R6 burst ended", int'(col_valid), 0);
      chk("R10 idle col zero", int'(col_out), 0);
    end

    // R2: inputs without load leave the mode alone
    load_mode(3'd2, 1'b0);
    mode_len = 3'd7;
    mode_ilv = 1'b1;
    launch(10'h041);
    for (int i = 0; i < 4; i++) begin
      chk("R2 held mode col", int'(col_out), exp_col(3'd2, 1'b0, 'h041, i));
      tick();
    end
    chk("R2 held mode length", int'(col_valid), 0);

    // R8: stop in the middle of an eight-beat burst
    load_mode(3'd3, 1'b0);
    launch(10'h010);
    tick();
    tick();
    chk("R8 beat before stop", int'(col_out), 'h012);
    stop = 1'b1;
    tick();
    stop = 1'b0;
    chk("R8 stop mid burst", int'(col_valid), 0);
    stop = 1'b1;
    tick();
    stop = 1'b0;
    chk("R8 stop while idle", int'(col_valid), 0);

    // R9: restart over a running burst, start wins over stop
    load_mode(3'd2, 1'b0);
    launch(10'h020);
    tick();
    chk("R9 running beat", int'(col_out), 'h021);
    start = 1'b1;
    start_col = 10'h105;
    stop = 1'b1;
    tick();
    start = 1'b0;
    stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R9 restart col", int'(col_out), exp_col(3'd2, 1'b0, 'h105, i));
      chk("R9 restart last", int'(col_last), (i == 3) ? 1 : 0);
      tick();
    end
    chk("R9 restart ends", int'(col_valid), 0);

    // R3/R9: column commands on consecutive cycles
    launch(10'h030);
    chk("R3 first command", int'(col_out), 'h030);
    launch(10'h031);
    chk("R9 back to back", int'(col_out), 'h031);
    tick();
    chk("R9 back to back next", int'(col_out), 'h032);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule